// File: doc/BRIEF.md
# Shared Event Counter Bank with Command-Port Access

This block is a performance-monitor bank of six 32-bit event counters that many agents share. Each counter picks one of several single-bit event pulse inputs by its event number. A counter adds one on every clock where its event is high, as long as counting is enabled both globally and for that counter. When a counter passes its top value it rolls over to zero and sets its overflow flag. One interrupt line serves every counter.

There is no memory map. Every access arrives as a 32-bit request word together with a 32-bit write value on a single command port. The block checks every field of the request. On the next clock it returns the read data and a coded status. Enable, overflow and interrupt-enable state each have a set register and a clear register, so software can change single bits without a read-modify-write. A secure input flag guards the one security register.

Top module: `uncore_evmon`

## Requirements
- R1: A request word carries command in [7:0], group in [11:8], unit in [15:12], register index in [23:16] and counter number in [31:24]. Command 0 reads and command 1 writes.
- R2: Each request gets exactly one status, found by checking these in order. Command above 1 gives 5. Group not 0 gives 1. Unit not 0 gives 2. Index above 13 gives 4. Counter number 6 or more on index 0 or 1 gives 3. A write to index 9 to 12 gives 6. Any access to index 13 while the secure input is low gives 7. Otherwise the status is 0. A rejected request changes no state and returns zero data.
- R3: The response is valid for exactly one clock, the clock after a request is taken. The status sits in bits [7:0] of the status word and the upper bits are zero. Data is the register value for a successful read and zero otherwise.
- R4: Counter i adds one on a clock where control bit E is set, enable bit i is set, and the event input named by its event number is high. An event number at or above NUM_EVENTS never counts.
- R5: A counter at 0xFFFFFFFF that increments becomes 0 and sets its overflow bit. On the same clock this takes priority over a software overflow clear.
- R6: A software write to a counter (index 0) takes priority over an increment on the same clock. A write at clock A followed by two increments reads back as the written value plus one at clock A+2.
- R7: The event-type register (index 1) stores the event number in bits [9:0] and the interrupt core in bits [19:16]. Its other bits read as zero.
- R8: The control register (index 6) stores E in bit 0. Writing 1 to bit 1 clears every counter, and that bit reads as 0. A read returns 0x4E in [31:24], 0 in [23:16] and 6 in [15:11], which gives 0x4E003000 with E clear.
- R9: Indices 2/3 (enable), 4/5 (overflow) and 7/8 (interrupt enable) are set/clear pairs. Writing 1s to the set index sets those bits, writing 1s to the clear index clears them, and reading either index returns the current 6-bit vector.
- R10: irqOut is high while any counter has both its overflow bit and its interrupt-enable bit set.
- R11: These read-only registers return fixed values. Index 9 returns 1. Index 10 returns a mask with bit j set for each implemented event j below 32 (0x0000FFFF by default). Index 11 returns the same for events 32 to 63. Index 12 returns FEATURE_WORD (0x00000011 by default).
- R12: Index 13 holds one secure bit in bit 0, readable and writable only while the secure input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this clock |
| reqWord | input | 32 | Command, group, unit, index and counter fields |
| reqData | input | 32 | Write value |
| secureIn | input | 1 | Requester is secure |
| evIn | input | NUM_EVENTS | Event pulse inputs |
| rspValid | output | 1 | Response valid |
| rspData | output | 32 | Read data |
| rspStatus | output | 32 | Status code in bits [7:0] |
| irqOut | output | 1 | Combined overflow interrupt |

## Verification
The assertions assume that reqValid, reqWord and reqData are free of X while reset is released. They also assume that the event inputs change only between clock edges. The bench drives every input on the falling edge from defined values, so both assumptions hold. Random requests are biased towards legal fields, and near-top counter values are seeded so that wraps occur. A reference model follows every clock to predict the responses and the interrupt line.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam logic [7:0] ST_OK        = 8'd0;
  localparam logic [7:0] ST_BAD_GROUP = 8'd1;
  localparam logic [7:0] ST_BAD_UNIT  = 8'd2;
  localparam logic [7:0] ST_BAD_CTR   = 8'd3;
  localparam logic [7:0] ST_BAD_REG   = 8'd4;
  localparam logic [7:0] ST_BAD_CMD   = 8'd5;
  localparam logic [7:0] ST_RDONLY    = 8'd6;
  localparam logic [7:0] ST_NOSEC     = 8'd7;

  localparam logic [7:0] IX_CNT    = 8'd0;
  localparam logic [7:0] IX_TYPE   = 8'd1;
  localparam logic [7:0] IX_EN_SET = 8'd2;
  localparam logic [7:0] IX_EN_CLR = 8'd3;
  localparam logic [7:0] IX_OV_SET = 8'd4;
  localparam logic [7:0] IX_OV_CLR = 8'd5;
  localparam logic [7:0] IX_CTRL   = 8'd6;
  localparam logic [7:0] IX_IE_SET = 8'd7;
  localparam logic [7:0] IX_IE_CLR = 8'd8;
  localparam logic [7:0] IX_UNITS  = 8'd9;
  localparam logic [7:0] IX_EVID0  = 8'd10;
  localparam logic [7:0] IX_EVID1  = 8'd11;
  localparam logic [7:0] IX_FEAT   = 8'd12;
  localparam logic [7:0] IX_SEC    = 8'd13;

  typedef struct packed {
    logic        wrCnt;
    logic        wrType;
    logic        enSet;
    logic        enClr;
    logic        ovSet;
    logic        ovClr;
    logic        ieSet;
    logic        ieClr;
    logic        wrCtrl;
    logic        wrSec;
    logic [7:0]  ctr;
    logic [31:0] data;
  } strobe_t;
endpackage

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int NUM_CNT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqWord,
  input  logic [31:0] reqData,
  input  logic        secureIn,
  input  logic [31:0] rdData,
  output strobe_t     stb,
  output logic [7:0]  rdIdx,
  output logic [7:0]  rdCtr,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic [31:0] rspStatus
);
  logic [7:0] cmd, idx, ctr, status;
  logic [3:0] grp, unit;
  logic       isWrite, doWrite;

  assign cmd  = reqWord[7:0];
  assign grp  = reqWord[11:8];
  assign unit = reqWord[15:12];
  assign idx  = reqWord[23:16];
  assign ctr  = reqWord[31:24];
  assign isWrite = (cmd == 8'd1);

  // ordered field checks
  always_comb begin
    if (cmd > 8'd1)                                    status = ST_BAD_CMD;
    else if (grp != 4'd0)                              status = ST_BAD_GROUP;
    else if (unit != 4'd0)                             status = ST_BAD_UNIT;
    else if (idx > IX_SEC)                             status = ST_BAD_REG;
    else if (idx <= IX_TYPE && ctr >= 8'(NUM_CNT))     status = ST_BAD_CTR;
    else if (isWrite && idx >= IX_UNITS && idx <= IX_FEAT) status = ST_RDONLY;
    else if (idx == IX_SEC && !secureIn)               status = ST_NOSEC;
    else                                               status = ST_OK;
  end

  assign doWrite = reqValid && (status == ST_OK) && isWrite;
  assign rdIdx = idx;
  assign rdCtr = ctr;

  always_comb begin
    stb        = '0;
    stb.ctr    = ctr;
    stb.data   = reqData;
    stb.wrCnt  = doWrite && idx == IX_CNT;
    stb.wrType = doWrite && idx == IX_TYPE;
    stb.enSet  = doWrite && idx == IX_EN_SET;
    stb.enClr  = doWrite && idx == IX_EN_CLR;
    stb.ovSet  = doWrite && idx == IX_OV_SET;
    stb.ovClr  = doWrite && idx == IX_OV_CLR;
    stb.wrCtrl = doWrite && idx == IX_CTRL;
    stb.ieSet  = doWrite && idx == IX_IE_SET;
    stb.ieClr  = doWrite && idx == IX_IE_CLR;
    stb.wrSec  = doWrite && idx == IX_SEC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      rspStatus <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspStatus <= {24'b0, status};
        rspData   <= (status == ST_OK && !isWrite) ? rdData : 32'b0;
      end
    end
  end

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r2_reject_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus[7:0] != ST_OK) |-> rspData == 32'b0);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCnt, stb.wrType, stb.enSet, stb.enClr, stb.ovSet,
              stb.ovClr, stb.ieSet, stb.ieClr, stb.wrCtrl, stb.wrSec}));
endmodule

// File: rtl/evmon_dp.sv
module evmon_dp
  import evmon_pkg::*;
#(
  parameter int          NUM_CNT      = 6,
  parameter int          NUM_EVENTS   = 16,
  parameter logic [31:0] FEATURE_WORD = 32'h0000_0011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [7:0]            rdIdx,
  input  logic [7:0]            rdCtr,
  input  logic [NUM_EVENTS-1:0] evIn,
  output logic [31:0]           rdData,
  output logic                  irqOut
);
  localparam logic [4:0] N_FIELD = 5'(NUM_CNT);

  logic [31:0]        cnt    [NUM_CNT];
  logic [9:0]         evtSel [NUM_CNT];
  logic [3:0]         coreSel[NUM_CNT];
  logic [NUM_CNT-1:0] enV, ovV, ieV, hit, incV, wrapV, swWr;
  logic               ctrlE, secBit, pRst;
  logic [NUM_CNT-1:0] maskV;

  assign pRst  = stb.wrCtrl && stb.data[1];
  assign maskV = stb.data[NUM_CNT-1:0];

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      hit[i] = 1'b0;
      for (int j = 0; j < NUM_EVENTS; j++)
        if (evtSel[i] == 10'(j)) hit[i] = evIn[j];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : gCtr
    assign swWr[i]  = stb.wrCnt && stb.ctr == 8'(i);
    assign incV[i]  = ctrlE && enV[i] && hit[i];
    assign wrapV[i] = incV[i] && !pRst && !swWr[i] && (&cnt[i]);

    always_ff @(posedge clk) begin
      if (!rstN)        cnt[i] <= '0;
      else if (swWr[i]) cnt[i] <= stb.data;
      else if (pRst)    cnt[i] <= '0;
      else if (incV[i]) cnt[i] <= cnt[i] + 32'd1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtSel[i]  <= '0;
        coreSel[i] <= '0;
      end else if (stb.wrType && stb.ctr == 8'(i)) begin
        evtSel[i]  <= stb.data[9:0];
        coreSel[i] <= stb.data[19:16];
      end
    end

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
      ((&cnt[i]) && incV[i] && !pRst && !swWr[i]) |=> (cnt[i] == 32'd0 && ovV[i]));
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rstN)
      swWr[i] |=> cnt[i] == $past(stb.data));
    a_r4_hold_off: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlE && !pRst && !swWr[i]) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enV <= '0; ovV <= '0; ieV <= '0; ctrlE <= 1'b0; secBit <= 1'b0;
    end else begin
      enV <= (enV | (stb.enSet ? maskV : '0)) & ~(stb.enClr ? maskV : '0);
      ieV <= (ieV | (stb.ieSet ? maskV : '0)) & ~(stb.ieClr ? maskV : '0);
      ovV <= ((ovV | (stb.ovSet ? maskV : '0)) & ~(stb.ovClr ? maskV : '0)) | wrapV;
      if (stb.wrCtrl) ctrlE  <= stb.data[0];
      if (stb.wrSec)  secBit <= stb.data[0];
    end
  end

  assign irqOut = |(ovV & ieV);

  logic [31:0] selCnt, selType, idLo, idHi;
  always_comb begin
    selCnt  = '0;
    selType = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rdCtr == 8'(i)) begin
        selCnt  = cnt[i];
        selType = {12'b0, coreSel[i], 6'b0, evtSel[i]};
      end
    for (int j = 0; j < 32; j++) begin
      idLo[j] = (j < NUM_EVENTS);
      idHi[j] = (j + 32 < NUM_EVENTS);
    end
  end

  always_comb begin
    case (rdIdx)
      IX_CNT:                 rdData = selCnt;
      IX_TYPE:                rdData = selType;
      IX_EN_SET, IX_EN_CLR:   rdData = 32'(enV);
      IX_OV_SET, IX_OV_CLR:   rdData = 32'(ovV);
      IX_IE_SET, IX_IE_CLR:   rdData = 32'(ieV);
      IX_CTRL:                rdData = {8'h4E, 8'h00, N_FIELD, 9'b0, 1'b0, ctrlE};
      IX_UNITS:               rdData = 32'd1;
      IX_EVID0:               rdData = idLo;
      IX_EVID1:               rdData = idHi;
      IX_FEAT:                rdData = FEATURE_WORD;
      IX_SEC:                 rdData = {31'b0, secBit};
      default:                rdData = '0;
    endcase
  end

  a_r10_irq_needs_ovf: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ovV != '0));
endmodule

// File: rtl/uncore_evmon.sv
module uncore_evmon
  import evmon_pkg::*;
#(
  parameter int          NUM_CNT      = 6,
  parameter int          NUM_EVENTS   = 16,
  parameter logic [31:0] FEATURE_WORD = 32'h0000_0011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [31:0]           reqWord,
  input  logic [31:0]           reqData,
  input  logic                  secureIn,
  input  logic [NUM_EVENTS-1:0] evIn,
  output logic                  rspValid,
  output logic [31:0]           rspData,
  output logic [31:0]           rspStatus,
  output logic                  irqOut
);
  strobe_t     stb;
  logic [7:0]  rdIdx, rdCtr;
  logic [31:0] rdData;

  evmon_ctrl #(.NUM_CNT(NUM_CNT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .reqData(reqData), .secureIn(secureIn), .rdData(rdData), .stb(stb),
    .rdIdx(rdIdx), .rdCtr(rdCtr), .rspValid(rspValid), .rspData(rspData),
    .rspStatus(rspStatus)
  );

  evmon_dp #(.NUM_CNT(NUM_CNT), .NUM_EVENTS(NUM_EVENTS),
             .FEATURE_WORD(FEATURE_WORD)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdIdx(rdIdx), .rdCtr(rdCtr),
    .evIn(evIn), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/uncore_evmon_test.sv
module uncore_evmon_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqWord = '0, reqData = '0;
  logic        secureIn = 1'b0;
  logic [15:0] evIn = '0;
  logic        rspValid, irqOut;
  logic [31:0] rspData, rspStatus;

  int checks = 0, errors = 0;
  bit evAllOnes = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uncore_evmon uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .reqData(reqData), .secureIn(secureIn), .evIn(evIn),
    .rspValid(rspValid), .rspData(rspData), .rspStatus(rspStatus),
    .irqOut(irqOut)
  );

  always @(negedge clk) evIn <= evAllOnes ? 16'hFFFF : 16'($urandom);

  // reference model
  logic [31:0] mCnt [6];
  logic [9:0]  mEvt [6];
  logic [3:0]  mCore[6];
  logic [5:0]  mEn, mOv, mIe, mInc, mWrap;
  logic        mE, mSec, mWr, mP;
  logic [7:0]  mSt, mCmd, mIdx, mCtr;
  logic [31:0] mRd;

  function automatic logic [7:0] expStatus(logic [31:0] w, logic sec);
    logic [7:0] c = w[7:0], ix = w[23:16], ct = w[31:24];
    if (c > 1) return 8'd5;
    if (w[11:8] != 0) return 8'd1;
    if (w[15:12] != 0) return 8'd2;
    if (ix > 13) return 8'd4;
    if (ix <= 1 && ct >= 6) return 8'd3;
    if (c == 1 && ix >= 9 && ix <= 12) return 8'd6;
    if (ix == 13 && !sec) return 8'd7;
    return 8'd0;
  endfunction

  function automatic logic [31:0] readModel(logic [7:0] ix, logic [7:0] ct);
    case (ix)
      0: return mCnt[ct];
      1: return {12'b0, mCore[ct], 6'b0, mEvt[ct]};
      2, 3: return {26'b0, mEn};
      4, 5: return {26'b0, mOv};
      6: return {16'h4E00, 16'h3000} | {31'b0, mE};
      7, 8: return {26'b0, mIe};
      9: return 32'd1;
      10: return 32'h0000_FFFF;
      11: return 32'd0;
      12: return 32'h0000_0011;
      13: return {31'b0, mSec};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 6; i++) begin mCnt[i] = 0; mEvt[i] = 0; mCore[i] = 0; end
      mEn = 0; mOv = 0; mIe = 0; mE = 0; mSec = 0; mSt = 0; mRd = 0;
    end else begin
      for (int i = 0; i < 6; i++)
        mInc[i] = mE && mEn[i] && (mEvt[i] < 16) && evIn[mEvt[i][3:0]];
      mCmd = reqWord[7:0]; mIdx = reqWord[23:16]; mCtr = reqWord[31:24];
      mWr = 1'b0;
      if (reqValid) begin
        mSt = expStatus(reqWord, secureIn);
        mRd = (mSt == 0 && mCmd == 0) ? readModel(mIdx, mCtr) : 32'd0;
        mWr = (mSt == 0 && mCmd == 1);
      end
      mP = mWr && mIdx == 6 && reqData[1];
      mWrap = 0;
      for (int i = 0; i < 6; i++) begin
        if (mWr && mIdx == 0 && mCtr == i) mCnt[i] = reqData;
        else if (mP) mCnt[i] = 0;
        else if (mInc[i]) begin
          if (mCnt[i] == 32'hFFFF_FFFF) mWrap[i] = 1'b1;
          mCnt[i] = mCnt[i] + 1;
        end
      end
      if (mWr && mIdx == 1) begin mEvt[mCtr] = reqData[9:0]; mCore[mCtr] = reqData[19:16]; end
      if (mWr && mIdx == 2) mEn = mEn | reqData[5:0];
      if (mWr && mIdx == 3) mEn = mEn & ~reqData[5:0];
      if (mWr && mIdx == 7) mIe = mIe | reqData[5:0];
      if (mWr && mIdx == 8) mIe = mIe & ~reqData[5:0];
      if (mWr && mIdx == 4) mOv = mOv | reqData[5:0];
      if (mWr && mIdx == 5) mOv = mOv & ~reqData[5:0];
      mOv = mOv | mWrap;
      if (mWr && mIdx == 6) mE = reqData[0];
      if (mWr && mIdx == 13) mSec = reqData[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input string tag, input logic [7:0] cmd, input logic [3:0] g,
                       input logic [3:0] u, input logic [7:0] ix, input logic [7:0] ct,
                       input logic [31:0] d, input bit sec);
    @(negedge clk);
    reqValid = 1'b1; reqWord = {ct, ix, u, g, cmd}; reqData = d; secureIn = sec;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R3 valid"}, {31'b0, rspValid}, 32'd1);
    chk({tag, " R2 status"}, rspStatus, {24'b0, mSt});
    chk({tag, " R3 data"}, rspData, mRd);
    chk({tag, " R10 irq"}, {31'b0, irqOut}, {31'b0, |(mOv & mIe)});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    chk("reset R3 valid low", {31'b0, rspValid}, 32'd0);
    chk("reset R10 irq low", {31'b0, irqOut}, 32'd0);
    doReq("R8 ctrl after reset", 0, 0, 0, 6, 0, 0, 0);
    chk("R8 ctrl value", rspData, 32'h4E00_3000);
    idle(1);
    chk("R3 single-cycle valid", {31'b0, rspValid}, 32'd0);
    doReq("R11 units", 0, 0, 0, 9, 0, 0, 0);      chk("R11 units", rspData, 32'd1);
    doReq("R11 evid0", 0, 0, 0, 10, 0, 0, 0);     chk("R11 evid0", rspData, 32'h0000_FFFF);
    doReq("R11 feat", 0, 0, 0, 12, 0, 0, 0);      chk("R11 feat", rspData, 32'h11);
    // rejections
    doReq("R1 bad cmd", 2, 0, 0, 0, 0, 0, 0);     chk("R1 cmd status", rspStatus, 5);
    doReq("R2 bad group", 0, 3, 0, 0, 0, 0, 0);   chk("R2 group status", rspStatus, 1);
    doReq("R2 bad unit", 0, 0, 1, 0, 0, 0, 0);    chk("R2 unit status", rspStatus, 2);
    doReq("R2 bad reg", 0, 0, 0, 14, 0, 0, 0);    chk("R2 reg status", rspStatus, 4);
    doReq("R2 bad ctr", 1, 0, 0, 0, 6, 5, 0);     chk("R2 ctr status", rspStatus, 3);
    doReq("R2 ro write", 1, 0, 0, 10, 0, 5, 0);   chk("R2 ro status", rspStatus, 6);
    doReq("R12 nosec", 1, 0, 0, 13, 0, 1, 0);     chk("R12 nosec status", rspStatus, 7);
    doReq("R12 sec wr", 1, 0, 0, 13, 0, 1, 1);
    doReq("R12 sec rd", 0, 0, 0, 13, 0, 0, 1);    chk("R12 sec value", rspData, 1);
    doReq("R2 rejected no effect", 0, 0, 0, 0, 0, 0, 0); chk("R2 cnt0 untouched", rspData, 0);
    // R7 type layout
    doReq("R7 type wr", 1, 0, 0, 1, 2, 32'hFFFF_FFFF, 0);
    doReq("R7 type rd", 0, 0, 0, 1, 2, 0, 0);     chk("R7 type value", rspData, 32'h000F_03FF);
    // R5 wrap and R10 irq
    evAllOnes = 1'b1;
    doReq("R5 cnt wr", 1, 0, 0, 0, 0, 32'hFFFF_FFFE, 0);
    doReq("R5 type0", 1, 0, 0, 1, 0, 0, 0);
    doReq("R9 ie set", 1, 0, 0, 7, 0, 1, 0);
    doReq("R9 en set", 1, 0, 0, 2, 0, 32'h3, 0);
    doReq("R4 type1 out of range", 1, 0, 0, 1, 1, 20, 0);
    doReq("R8 enable", 1, 0, 0, 6, 0, 1, 0);
    idle(3);
    doReq("R5 ovf rd", 0, 0, 0, 4, 0, 0, 0);      chk("R5 ovf bit0", rspData & 1, 1);
    chk("R10 irq high", {31'b0, irqOut}, 1);
    doReq("R4 cnt1 rd", 0, 0, 0, 0, 1, 0, 0);     chk("R4 cnt1 stays zero", rspData, 0);
    doReq("R9 ovf clr", 1, 0, 0, 5, 0, 1, 0);
    doReq("R9 en rd", 0, 0, 0, 3, 0, 0, 0);       chk("R9 en vector", rspData, 3);
    chk("R10 irq cleared", {31'b0, irqOut}, 0);
    doReq("R6 cnt wr", 1, 0, 0, 0, 0, 5, 0);
    doReq("R6 cnt rd", 0, 0, 0, 0, 0, 0, 0);      chk("R6 write wins", rspData, 6);
    doReq("R8 p reset", 1, 0, 0, 6, 0, 3, 0);
    doReq("R8 cnt after p", 0, 0, 0, 0, 0, 0, 0); chk("R8 p cleared", rspData, 1);
    doReq("R8 ctrl rd", 0, 0, 0, 6, 0, 0, 0);     chk("R8 p reads zero", rspData, 32'h4E00_3001);
    evAllOnes = 1'b0;
    // constrained random
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      logic [7:0] c, ix, ct;
      logic [3:0] g, u;
      logic [31:0] d;
      c  = ($urandom % 10 == 0) ? 8'(2 + $urandom % 3) : 8'($urandom % 2);
      g  = ($urandom % 12 == 0) ? 4'd1 : 4'd0;
      u  = ($urandom % 12 == 0) ? 4'd2 : 4'd0;
      ix = 8'($urandom % 15);
      ct = 8'($urandom % 8);
      d  = $urandom;
      if (ix == 0 && $urandom % 2 == 1) d = 32'hFFFF_FFF0 | 32'($urandom % 16);
      if (ix == 1) d = {12'b0, 4'($urandom), 6'b0, 10'($urandom % 24)};
      doReq("R1 random", c, g, u, ix, ct, d, 1'($urandom));
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule